// File: doc/BRIEF.md
# Streaming Soft-Symbol Depuncturer

The block sits in front of a rate-1/2 soft-decision Viterbi decoder. A punctured code stream arrives one soft symbol per clock, and the block turns it back into the two-symbol vectors that the decoder consumes. A fixed keep/drop pattern is defined for each of the two code-bit rows. Wherever the transmitter removed a code bit, the block puts an all-zero soft symbol, which is the neutral erasure value for the decoder.

The block runs on the received-symbol clock only. A column of the pattern keeps one or two symbols, so on some clocks no pair can be completed. On those clocks the output valid stays low, and the decoder downstream holds its state. The parameter `RATE_NUM` selects the punctured rate RATE_NUM/(RATE_NUM+1). The pattern then repeats every `RATE_NUM` columns, and over each period `RATE_NUM+1` received symbols produce `RATE_NUM` pairs.

Top module: `sym_depunct`

## Requirements
- R1: `RATE_NUM` = 2, 3, 4, 5 or 6 selects the keep pattern, with column 0 written first and 1 meaning kept. Row A: 10 / 101 / 1000 / 10101 / 100101. Row B: 11 / 110 / 1111 / 11010 / 111010. The pattern repeats after `RATE_NUM` columns.
- R2: Each pair on `out_pair` places the row-A symbol in bits [2*SYM_W-1:SYM_W] and the row-B symbol in bits [SYM_W-1:0]. Within a column the kept A symbol is received before the kept B symbol.
- R3: A position that the pattern drops is output as an all-zero symbol.
- R4: Each clock with `in_en` high consumes exactly one symbol. The symbol that completes a column gives `out_vld` high with that column's pair on the next clock.
- R5: `out_vld` is low on every clock that follows a clock with no column completed. This includes every clock after one with `in_en` low.
- R6: While `in_en` is low, `in_sym` is ignored and the pattern position and any held A symbol are kept unchanged.
- R7: Asynchronous active-low reset returns the pattern to column 0, discards any held A symbol and clears `out_vld` and `out_pair` to 0.
- R8: With `in_en` held high from reset, every `RATE_NUM+1` symbols give exactly `RATE_NUM` valid pairs. `out_vld` is never low on two consecutive clocks.
- R9: `out_pair` keeps its last value while `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Received-symbol clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_en | input | 1 | High when `in_sym` carries a received symbol |
| in_sym | input | SYM_W | Received soft symbol, two's complement |
| out_vld | output | 1 | High when `out_pair` holds a newly completed pair |
| out_pair | output | 2*SYM_W | Row-A symbol in the upper half, row-B symbol in the lower half |

## Verification
The hardest case to reach is a stall or a reset that lands between the A and B symbols of a column that keeps both. This is the only case where the block holds a partial pair. The bench builds one instance for each of the five rates. It drives random enable patterns, long stalls and a reset part-way through a stream, so each rate meets stalls and resets at every column position and with a half-built pair held. Random garbage appears on `in_sym` during stalls, so a symbol leaking into the pair would show. A 420-symbol window from reset is a common multiple of every period, and it checks the exact pair count for each rate.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   localparam int MAX_COLS = 6;

   // bit c of the result is the keep flag of pattern column c
   function automatic logic [MAX_COLS-1:0] keep_row_a(input int k);
      case (k)
         2:       return 6'b000001;
         3:       return 6'b000101;
         4:       return 6'b000001;
         5:       return 6'b010101;
         6:       return 6'b101001;
         default: return '0;
      endcase
   endfunction

   function automatic logic [MAX_COLS-1:0] keep_row_b(input int k);
      case (k)
         2:       return 6'b000011;
         3:       return 6'b000011;
         4:       return 6'b001111;
         5:       return 6'b001011;
         6:       return 6'b010111;
         default: return '0;
      endcase
   endfunction
endpackage

// File: rtl/sdp_col_ctr.sv
module sdp_col_ctr #(
   parameter int PERIOD = 2,
   parameter int COL_W  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [COL_W-1:0] col
);
   localparam logic [COL_W-1:0] LAST = COL_W'(PERIOD - 1);

   generate
      if ((PERIOD & (PERIOD - 1)) == 0) begin : g_pow2
         // period fills the counter exactly: natural wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    col <= '0;
            else if (step) col <= col + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    col <= '0;
            else if (step) col <= (col == LAST) ? '0 : col + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/sdp_keep_lut.sv
module sdp_keep_lut
   import sdp_pkg::*;
#(
   parameter int RATE_NUM = 2,
   parameter int COL_W    = 1
) (
   input  logic [COL_W-1:0] col,
   output logic             keep_a,
   output logic             keep_b
);
   localparam logic [MAX_COLS-1:0] ROW_A = keep_row_a(RATE_NUM);
   localparam logic [MAX_COLS-1:0] ROW_B = keep_row_b(RATE_NUM);

   logic [RATE_NUM-1:0] row_a_v;
   logic [RATE_NUM-1:0] row_b_v;

   assign row_a_v = ROW_A[RATE_NUM-1:0];
   assign row_b_v = ROW_B[RATE_NUM-1:0];
   assign keep_a  = row_a_v[col];
   assign keep_b  = row_b_v[col];
endmodule

// File: rtl/sdp_pair_asm.sv
module sdp_pair_asm #(
   parameter int SYM_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_en,
   input  logic [SYM_W-1:0]   in_sym,
   input  logic               keep_a,
   input  logic               keep_b,
   output logic               col_done,
   output logic               out_vld,
   output logic [2*SYM_W-1:0] out_pair
);
   localparam logic [SYM_W-1:0] ERASE = '0;

   logic               held_q;
   logic [SYM_W-1:0]   hold_q;
   logic               take_a;
   logic               closes;
   logic [2*SYM_W-1:0] pair_d;

   always_comb begin
      take_a = in_en && keep_a && !held_q;
      closes = in_en && !(take_a && keep_b);
      if (take_a) pair_d = {in_sym, ERASE};
      else        pair_d = {(keep_a ? hold_q : ERASE), in_sym};
   end

   assign col_done = closes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q   <= 1'b0;
         hold_q   <= '0;
         out_vld  <= 1'b0;
         out_pair <= '0;
      end else begin
         if (in_en) begin
            held_q <= take_a && keep_b;
            if (take_a && keep_b) hold_q <= in_sym;
         end
         out_vld <= closes;
         if (closes) out_pair <= pair_d;
      end
   end
endmodule

// File: rtl/sym_depunct.sv
module sym_depunct #(
   parameter int SYM_W    = 4,
   parameter int RATE_NUM = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_en,
   input  logic [SYM_W-1:0]   in_sym,
   output logic               out_vld,
   output logic [2*SYM_W-1:0] out_pair
);
   localparam int COL_W = (RATE_NUM > 1) ? $clog2(RATE_NUM) : 1;

   generate
      if (RATE_NUM < 2 || RATE_NUM > 6) begin : g_bad_rate
         $error("sym_depunct: RATE_NUM must lie in 2..6");
      end
      if (SYM_W < 2) begin : g_bad_width
         $error("sym_depunct: SYM_W must be at least 2");
      end
   endgenerate

   logic [COL_W-1:0] col;
   logic             keep_a;
   logic             keep_b;
   logic             col_done;

   sdp_col_ctr #(.PERIOD(RATE_NUM), .COL_W(COL_W)) u_col (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (col_done),
      .col   (col)
   );

   sdp_keep_lut #(.RATE_NUM(RATE_NUM), .COL_W(COL_W)) u_lut (
      .col    (col),
      .keep_a (keep_a),
      .keep_b (keep_b)
   );

   sdp_pair_asm #(.SYM_W(SYM_W)) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_en    (in_en),
      .in_sym   (in_sym),
      .keep_a   (keep_a),
      .keep_b   (keep_b),
      .col_done (col_done),
      .out_vld  (out_vld),
      .out_pair (out_pair)
   );
endmodule

// File: rtl/sym_depunct_chk.sv
module sym_depunct_chk
   import sdp_pkg::*;
#(
   parameter int SYM_W    = 4,
   parameter int RATE_NUM = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_en,
   input logic               out_vld,
   input logic [2*SYM_W-1:0] out_pair
);
   localparam logic [MAX_COLS-1:0] ROW_A = keep_row_a(RATE_NUM);
   localparam logic [MAX_COLS-1:0] ROW_B = keep_row_b(RATE_NUM);

   logic ok1, ok2;
   int   oc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok1 <= 1'b0;
         ok2 <= 1'b0;
         oc  <= 0;
      end else begin
         ok1 <= 1'b1;
         ok2 <= ok1;
         if (out_vld) oc <= (oc == RATE_NUM - 1) ? 0 : oc + 1;
      end
   end

   AST_VLD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (ok1 && out_vld) |-> $past(in_en)); // R5

   AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ok1 && !out_vld) |-> $stable(out_pair)); // R9

   AST_NO_DOUBLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ok2 && $past(in_en) && $past(in_en, 2)) |-> (out_vld || $past(out_vld))); // R8

   AST_ERASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ((ROW_A[oc] || out_pair[2*SYM_W-1:SYM_W] == '0) &&
                   (ROW_B[oc] || out_pair[SYM_W-1:0] == '0))); // R3
endmodule

bind sym_depunct sym_depunct_chk #(.SYM_W(SYM_W), .RATE_NUM(RATE_NUM)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_en    (in_en),
   .out_vld  (out_vld),
   .out_pair (out_pair)
);

// File: tb/sym_depunct_bench.sv
module sym_depunct_bench;
   localparam int W   = 4;
   localparam int WIN = 420;   // common multiple of every period + 1

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic in_en = 1'b0;
   logic win_done = 1'b0;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   ended = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   function automatic string row_a(input int k);
      case (k) 2: return "10"; 3: return "101"; 4: return "1000";
               5: return "10101"; default: return "100101"; endcase
   endfunction
   function automatic string row_b(input int k);
      case (k) 2: return "11"; 3: return "110"; 4: return "1111";
               5: return "11010"; default: return "111010"; endcase
   endfunction

   task automatic check(input bit ok, input string req, input int k,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s rate %0d/%0d: actual %0h expected %0h at %0t",
                  req, k, k + 1, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   for (genvar gi = 0; gi < 5; gi++) begin : g_rate
      localparam int K = gi + 2;
      logic           d_vld;
      logic [2*W-1:0] d_pair;
      logic [W-1:0]   d_sym = '0;

      sym_depunct #(.SYM_W(W), .RATE_NUM(K)) u_sym_depunct (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_en    (in_en),
         .in_sym   (d_sym),
         .out_vld  (d_vld),
         .out_pair (d_pair)
      );

      // reference: puncture a random pair stream, predict output per clock
      logic [W-1:0]   q_sym[$];
      bit             q_last[$];
      logic [2*W-1:0] q_pair[$];
      int             mcol = 0;
      int             nval = 0;
      bit             ev = 1'b0;
      logic [2*W-1:0] ep = '0;

      task automatic refill();
         string ra = row_a(K), rb = row_b(K);
         bit ka = (ra[mcol] == "1"), kb = (rb[mcol] == "1");
         logic [W-1:0] a = W'($urandom_range(1, 15));
         logic [W-1:0] b = W'($urandom_range(1, 15));
         if (ka) begin q_sym.push_back(a); q_last.push_back(!kb); end
         if (kb) begin q_sym.push_back(b); q_last.push_back(1'b1); end
         // R1 R2 R3: A upper, B lower, dropped position zero
         q_pair.push_back({ka ? a : W'(0), kb ? b : W'(0)});
         mcol = (mcol == K - 1) ? 0 : mcol + 1;
      endtask

      always @(negedge clk) begin
         if (!rst_n) begin
            // R7: reset state
            check(d_vld == 1'b0 && d_pair == '0, "R7", K, {d_vld, d_pair}, 0);
            q_sym.delete(); q_last.delete(); q_pair.delete();
            mcol = 0; nval = 0; ev = 1'b0; ep = '0;
         end else begin
            check(d_vld == ev, "R4/R5 out_vld", K, d_vld, ev);
            check(d_pair == ep, "R2/R3/R9 out_pair", K, d_pair, ep);
            if (d_vld) nval++;
            if (win_done)   // R8: pair count over the window from reset
               check(nval == WIN * K / (K + 1), "R8 pair count", K, nval, WIN * K / (K + 1));
            if (in_en) begin
               bit l;
               if (q_sym.size() == 0) refill();
               d_sym = q_sym.pop_front();
               l = q_last.pop_front();
               ev = l;
               if (l) ep = q_pair.pop_front();
            end else begin
               ev = 1'b0;            // R6: garbage while stalled
               d_sym = W'($urandom);
            end
         end
      end
   end

   task automatic step(input bit en);
      @(posedge clk); #1 in_en = en;
   endtask

   task automatic do_reset();
      @(posedge clk); #1 rst_n = 1'b0; in_en = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R8: continuous window from reset
      for (int i = 0; i < WIN; i++) step(1'b1);
      repeat (3) step(1'b0);
      @(posedge clk); #1 win_done = 1'b1;
      @(posedge clk); #1 win_done = 1'b0;
      // R6: random stalls
      for (int i = 0; i < 600; i++) step($urandom_range(0, 9) < 7);
      // R6: long stall then burst
      for (int i = 0; i < 20; i++) step(1'b0);
      for (int i = 0; i < 50; i++) step(1'b1);
      // R7: reset part-way through a stream, held A discarded
      for (int k = 0; k < 5; k++) begin
         for (int i = 0; i < 7 + k; i++) step(1'b1);
         do_reset();
         for (int i = 0; i < 60; i++) step($urandom_range(0, 3) != 0);
      end
      repeat (3) step(1'b0);
      finish_run();
   end

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule